// File: doc/BRIEF.md
# Fork-Join Dual-Unit Result Comparator

This controller runs one operand through two request/response units side by side: a trusted reference model and a unit under test. One start command latches the operand. Both branches then send it out at the same time. Each branch runs its own request-then-response sequence, at whatever pace its unit sets, and keeps the returned value in a result register of its own.

Once both branches report finished, a single comparison cycle judges the two results. The compare waits on a join of both branches, not on a fixed order. The controller reports done while it is idle. It pulses a compare strobe with a pass bit, and it keeps a sticky error flag once any compare has failed. Two running counters record every request sent and every response taken across both units.

Result width, operand width, counter width and an optional compare mask are parameters. When the mask covers every bit, elaboration builds a plain equality comparator; otherwise it builds a masked one.

Top module: `fork_join_compare`

## Requirements
- R1: `start_i` is accepted only on a clock edge where `done_o` is 1. The operand on `in_data_i` at that edge goes to both units as request data, and a start raised while busy is ignored.
- R2: In the cycle after an accepted start, both `ref_req_valid_o` and `dut_req_valid_o` are 1.
- R3: A branch holds its request valid, with unchanged data, until the unit's ready is seen. After that handshake it drops valid and issues no second request in the same run.
- R4: A branch drives its response ready to 1 only after its request handshake. It takes the response data on the edge where valid and ready are both 1, and holds that value as its result.
- R5: `done_o` is 1 exactly when the controller is idle: after reset, and from the cycle after a compare onward until the next accepted start.
- R6: `cmp_valid_o` rises two cycles after the later of the two response handshakes. With the start on edge 1, a request-ready delay of q cycles and a response delay of r cycles per unit, it is seen on cycle 4+max(q+r) over both units.
- R7: `cmp_valid_o` is a one-cycle pulse. During that pulse `cmp_pass_o` is 1 when the two held results agree on every bit of the compare mask (default: all bits), and it is 0 otherwise.
- R8: `err_sticky_o` goes to 1 after a compare with `cmp_pass_o` at 0 and stays 1 until reset.
- R9: `req_count_o` adds one per request handshake on either unit, and `rsp_count_o` adds one per response handshake, so a full run adds 2 to each.
- R10: While reset is held, `done_o` is 1, both counters are 0, `err_sticky_o` is 0, and no valid, ready or compare output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request |
| in_data_i | input | DATA_W | Operand for both units |
| done_o | output | 1 | Controller idle |
| ref_req_valid_o | output | 1 | Reference request valid |
| ref_req_data_o | output | DATA_W | Reference request operand |
| ref_req_ready_i | input | 1 | Reference accepts request |
| ref_rsp_valid_i | input | 1 | Reference result valid |
| ref_rsp_data_i | input | RES_W | Reference result |
| ref_rsp_ready_o | output | 1 | Controller takes reference result |
| dut_req_valid_o | output | 1 | Unit-under-test request valid |
| dut_req_data_o | output | DATA_W | Unit-under-test request operand |
| dut_req_ready_i | input | 1 | Unit under test accepts request |
| dut_rsp_valid_i | input | 1 | Unit-under-test result valid |
| dut_rsp_data_i | input | RES_W | Unit-under-test result |
| dut_rsp_ready_o | output | 1 | Controller takes unit-under-test result |
| cmp_valid_o | output | 1 | Compare strobe, one cycle |
| cmp_pass_o | output | 1 | Results matched (valid with strobe) |
| err_sticky_o | output | 1 | A mismatch has occurred |
| req_count_o | output | CNT_W | Requests issued |
| rsp_count_o | output | CNT_W | Responses consumed |

## Verification
Suppose a branch sequencer is stuck or has skipped a state. The ports show it within one run. Request valid would be missing in the cycle after start, or still asserted after its handshake. Response ready would come up before the request was taken, or the compare strobe would arrive on a cycle other than 4+max(q+r). A join that fires on only one finished flag makes the strobe early whenever the two units' delays differ. A result register that misses its capture edge flips the pass bit in that same run. Counter or sticky-flag faults show as a count that is not 2 per run, or as an error flag that differs from the bench's record of injected mismatches at the end of the run.

// File: rtl/fjc_pkg.sv
package fjc_pkg;

   typedef enum logic [1:0] {
      BR_IDLE = 2'd0,
      BR_REQ  = 2'd1,
      BR_RSP  = 2'd2,
      BR_FIN  = 2'd3
   } br_state_t;

   typedef enum logic [1:0] {
      CT_IDLE = 2'd0,
      CT_RUN  = 2'd1,
      CT_CMP  = 2'd2
   } ct_state_t;

endpackage

// File: rtl/fjc_branch.sv
module fjc_branch
   import fjc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int RES_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic              clear_i,
   input  logic [DATA_W-1:0] op_i,
   output logic              req_valid_o,
   output logic [DATA_W-1:0] req_data_o,
   input  logic              req_ready_i,
   input  logic              rsp_valid_i,
   input  logic [RES_W-1:0]  rsp_data_i,
   output logic              rsp_ready_o,
   output logic [RES_W-1:0]  result_o,
   output logic              fin_o,
   output logic              req_fire_o,
   output logic              rsp_fire_o
);

   br_state_t            state_q;
   logic [RES_W-1:0]     result_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= BR_IDLE;
         result_q <= '0;
      end else begin
         case (state_q)
            BR_IDLE: if (launch_i) state_q <= BR_REQ;
            BR_REQ:  if (req_ready_i) state_q <= BR_RSP;
            BR_RSP:  if (rsp_valid_i) begin
                        result_q <= rsp_data_i;
                        state_q  <= BR_FIN;
                     end
            BR_FIN:  if (clear_i) state_q <= BR_IDLE;
            default: state_q <= BR_IDLE;
         endcase
      end
   end

   always_comb begin
      req_valid_o = (state_q == BR_REQ);
      rsp_ready_o = (state_q == BR_RSP);
      fin_o       = (state_q == BR_FIN);
      req_data_o  = op_i;
      result_o    = result_q;
      req_fire_o  = req_valid_o && req_ready_i;
      rsp_fire_o  = rsp_ready_o && rsp_valid_i;
   end

endmodule

// File: rtl/fjc_join_ctrl.sv
module fjc_join_ctrl
   import fjc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic ref_fin_i,
   input  logic dut_fin_i,
   output logic launch_o,
   output logic cmp_en_o,
   output logic done_o
);

   ct_state_t state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CT_IDLE;
      end else begin
         case (state_q)
            CT_IDLE: if (start_i) state_q <= CT_RUN;
            CT_RUN:  if (ref_fin_i && dut_fin_i) state_q <= CT_CMP;
            CT_CMP:  state_q <= CT_IDLE;
            default: state_q <= CT_IDLE;
         endcase
      end
   end

   always_comb begin
      done_o   = (state_q == CT_IDLE);
      launch_o = done_o && start_i;
      cmp_en_o = (state_q == CT_CMP);
   end

endmodule

// File: rtl/fjc_compare.sv
module fjc_compare #(
   parameter int               RES_W    = 8,
   parameter logic [RES_W-1:0] RES_MASK = '1
) (
   input  logic [RES_W-1:0] a_i,
   input  logic [RES_W-1:0] b_i,
   output logic             eq_o
);

   localparam logic [RES_W-1:0] FULL_MASK = '1;

   generate
      if (RES_MASK == FULL_MASK) begin : g_full
         assign eq_o = (a_i == b_i);
      end else begin : g_masked
         assign eq_o = (((a_i ^ b_i) & RES_MASK) == '0);
      end
   endgenerate

endmodule

// File: rtl/fjc_evcount.sv
module fjc_evcount #(
   parameter int CNT_W = 16,
   parameter int N_EV  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EV-1:0]  ev_i,
   output logic [CNT_W-1:0] count_o
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_q + CNT_W'($countones(ev_i));
   end

   assign count_o = count_q;

endmodule

// File: rtl/fork_join_compare.sv
module fork_join_compare
   import fjc_pkg::*;
#(
   parameter int               DATA_W   = 8,
   parameter int               RES_W    = 8,
   parameter int               CNT_W    = 16,
   parameter logic [RES_W-1:0] RES_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] in_data_i,
   output logic              done_o,
   output logic              ref_req_valid_o,
   output logic [DATA_W-1:0] ref_req_data_o,
   input  logic              ref_req_ready_i,
   input  logic              ref_rsp_valid_i,
   input  logic [RES_W-1:0]  ref_rsp_data_i,
   output logic              ref_rsp_ready_o,
   output logic              dut_req_valid_o,
   output logic [DATA_W-1:0] dut_req_data_o,
   input  logic              dut_req_ready_i,
   input  logic              dut_rsp_valid_i,
   input  logic [RES_W-1:0]  dut_rsp_data_i,
   output logic              dut_rsp_ready_o,
   output logic              cmp_valid_o,
   output logic              cmp_pass_o,
   output logic              err_sticky_o,
   output logic [CNT_W-1:0]  req_count_o,
   output logic [CNT_W-1:0]  rsp_count_o
);

   localparam int N_UNITS = 2;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("fork_join_compare: DATA_W must be at least 1");
      end
      if (RES_W < 1) begin : g_bad_res_w
         $error("fork_join_compare: RES_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("fork_join_compare: CNT_W must be at least 2");
      end
   endgenerate

   logic              launch;
   logic              cmp_en;
   logic              ref_fin;
   logic              dut_fin;
   logic              results_eq;
   logic [DATA_W-1:0] operand_q;
   logic [RES_W-1:0]  ref_result;
   logic [RES_W-1:0]  dut_result;
   logic [N_UNITS-1:0] req_fire;
   logic [N_UNITS-1:0] rsp_fire;
   logic              err_q;

   // Operand latch: written only on an accepted start, stable for the run
   always_ff @(posedge clk) begin
      if (!rst_n)      operand_q <= '0;
      else if (launch) operand_q <= in_data_i;
   end

   fjc_join_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .ref_fin_i (ref_fin),
      .dut_fin_i (dut_fin),
      .launch_o  (launch),
      .cmp_en_o  (cmp_en),
      .done_o    (done_o)
   );

   fjc_branch #(.DATA_W(DATA_W), .RES_W(RES_W)) u_ref_branch (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch_i    (launch),
      .clear_i     (cmp_en),
      .op_i        (operand_q),
      .req_valid_o (ref_req_valid_o),
      .req_data_o  (ref_req_data_o),
      .req_ready_i (ref_req_ready_i),
      .rsp_valid_i (ref_rsp_valid_i),
      .rsp_data_i  (ref_rsp_data_i),
      .rsp_ready_o (ref_rsp_ready_o),
      .result_o    (ref_result),
      .fin_o       (ref_fin),
      .req_fire_o  (req_fire[0]),
      .rsp_fire_o  (rsp_fire[0])
   );

   fjc_branch #(.DATA_W(DATA_W), .RES_W(RES_W)) u_dut_branch (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch_i    (launch),
      .clear_i     (cmp_en),
      .op_i        (operand_q),
      .req_valid_o (dut_req_valid_o),
      .req_data_o  (dut_req_data_o),
      .req_ready_i (dut_req_ready_i),
      .rsp_valid_i (dut_rsp_valid_i),
      .rsp_data_i  (dut_rsp_data_i),
      .rsp_ready_o (dut_rsp_ready_o),
      .result_o    (dut_result),
      .fin_o       (dut_fin),
      .req_fire_o  (req_fire[1]),
      .rsp_fire_o  (rsp_fire[1])
   );

   fjc_compare #(.RES_W(RES_W), .RES_MASK(RES_MASK)) u_cmp (
      .a_i  (ref_result),
      .b_i  (dut_result),
      .eq_o (results_eq)
   );

   fjc_evcount #(.CNT_W(CNT_W), .N_EV(N_UNITS)) u_req_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_i    (req_fire),
      .count_o (req_count_o)
   );

   fjc_evcount #(.CNT_W(CNT_W), .N_EV(N_UNITS)) u_rsp_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_i    (rsp_fire),
      .count_o (rsp_count_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                     err_q <= 1'b0;
      else if (cmp_en && !results_eq) err_q <= 1'b1;
   end

   always_comb begin
      cmp_valid_o  = cmp_en;
      cmp_pass_o   = cmp_en && results_eq;
      err_sticky_o = err_q;
   end

endmodule

// File: rtl/fjc_checker.sv
module fjc_checker #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done_o,
   input logic              ref_req_valid_o,
   input logic [DATA_W-1:0] ref_req_data_o,
   input logic              ref_req_ready_i,
   input logic              ref_rsp_valid_i,
   input logic              ref_rsp_ready_o,
   input logic              dut_req_valid_o,
   input logic [DATA_W-1:0] dut_req_data_o,
   input logic              dut_req_ready_i,
   input logic              dut_rsp_valid_i,
   input logic              dut_rsp_ready_o,
   input logic              cmp_valid_o,
   input logic              cmp_pass_o,
   input logic              err_sticky_o,
   input logic [CNT_W-1:0]  req_count_o,
   input logic [CNT_W-1:0]  rsp_count_o,
   input logic              ref_fin,
   input logic              dut_fin
);

   // R1: both units see the same operand whenever both request
   a_r1_same_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req_valid_o && dut_req_valid_o) |-> (ref_req_data_o == dut_req_data_o));

   // R3: request held with stable data until accepted
   a_r3_ref_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req_valid_o && !ref_req_ready_i) |=> (ref_req_valid_o && $stable(ref_req_data_o)));
   a_r3_dut_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dut_req_valid_o && !dut_req_ready_i) |=> (dut_req_valid_o && $stable(dut_req_data_o)));

   // R4: response ready never overlaps the request phase
   a_r4_ref_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !(ref_rsp_ready_o && ref_req_valid_o));
   a_r4_dut_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !(dut_rsp_ready_o && dut_req_valid_o));

   // R5: idle controller drives no traffic
   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !(ref_req_valid_o || dut_req_valid_o || ref_rsp_ready_o || dut_rsp_ready_o || cmp_valid_o));

   // R6: compare only after both branches were finished
   a_r6_join: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_valid_o) |-> $past(ref_fin && dut_fin));

   // R7: single-cycle strobe, pass only with strobe, idle afterwards
   a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid_o |=> (!cmp_valid_o && done_o));
   a_r7_pass_gated: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_pass_o |-> cmp_valid_o);

   // R8: failed compare sets the sticky flag, which never clears
   a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid_o && !cmp_pass_o) |=> err_sticky_o);
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky_o |=> err_sticky_o);

   // R9: counters track handshakes
   a_r9_req_count: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (req_count_o == CNT_W'($past(req_count_o)
         + CNT_W'($past(ref_req_valid_o && ref_req_ready_i))
         + CNT_W'($past(dut_req_valid_o && dut_req_ready_i)))));
   a_r9_rsp_count: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rsp_count_o == CNT_W'($past(rsp_count_o)
         + CNT_W'($past(ref_rsp_ready_o && ref_rsp_valid_i))
         + CNT_W'($past(dut_rsp_ready_o && dut_rsp_valid_i)))));

endmodule

bind fork_join_compare fjc_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/fork_join_compare_test.sv
module fork_join_compare_test;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int RES_W      = 8;
   localparam int CNT_W      = 16;
   localparam int WATCHDOG   = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [DATA_W-1:0] in_data_i = '0;
   logic              done_o;
   logic              ref_req_valid_o, dut_req_valid_o;
   logic [DATA_W-1:0] ref_req_data_o, dut_req_data_o;
   logic              ref_req_ready_i = 1'b0, dut_req_ready_i = 1'b0;
   logic              ref_rsp_valid_i = 1'b0, dut_rsp_valid_i = 1'b0;
   logic [RES_W-1:0]  ref_rsp_data_i = '0, dut_rsp_data_i = '0;
   logic              ref_rsp_ready_o, dut_rsp_ready_o;
   logic              cmp_valid_o, cmp_pass_o, err_sticky_o;
   logic [CNT_W-1:0]  req_count_o, rsp_count_o;

   int checks = 0;
   int failures = 0;
   logic [DATA_W-1:0] ref_seen, dut_seen;

   always #(CLK_PERIOD/2) clk = ~clk;

   fork_join_compare #(.DATA_W(DATA_W), .RES_W(RES_W), .CNT_W(CNT_W)) uut (.*);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [RES_W-1:0] model(input logic [DATA_W-1:0] x);
      return RES_W'(x * 3 + 1);
   endfunction

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      summary();
      $finish;
   end

   // Unit model: q cycles before request ready, r cycles before result
   task automatic ref_side(input int q, input int r, input logic [DATA_W-1:0] x);
      @(negedge clk);
      chk(ref_req_valid_o == 1'b1, "R2 ref valid after start", ref_req_valid_o, 1);
      chk(ref_rsp_ready_o == 1'b0, "R4 ref rsp ready before req", ref_rsp_ready_o, 0);
      repeat (q) begin
         @(negedge clk);
         chk(ref_req_valid_o && ref_req_data_o == x, "R3 ref req held", ref_req_data_o, x);
      end
      ref_seen = ref_req_data_o;
      ref_req_ready_i = 1'b1;
      @(negedge clk);
      ref_req_ready_i = 1'b0;
      chk(ref_req_valid_o == 1'b0, "R3 ref single request", ref_req_valid_o, 0);
      chk(ref_rsp_ready_o == 1'b1, "R4 ref rsp ready", ref_rsp_ready_o, 1);
      repeat (r) @(negedge clk);
      ref_rsp_data_i = model(ref_seen);
      ref_rsp_valid_i = 1'b1;
      @(negedge clk);
      ref_rsp_valid_i = 1'b0;
      ref_rsp_data_i = '0;
   endtask

   task automatic dut_side(input int q, input int r, input logic [DATA_W-1:0] x, input bit bad);
      @(negedge clk);
      chk(dut_req_valid_o == 1'b1, "R2 dut valid after start", dut_req_valid_o, 1);
      chk(dut_rsp_ready_o == 1'b0, "R4 dut rsp ready before req", dut_rsp_ready_o, 0);
      repeat (q) begin
         @(negedge clk);
         chk(dut_req_valid_o && dut_req_data_o == x, "R3 dut req held", dut_req_data_o, x);
      end
      dut_seen = dut_req_data_o;
      dut_req_ready_i = 1'b1;
      @(negedge clk);
      dut_req_ready_i = 1'b0;
      chk(dut_rsp_ready_o == 1'b1, "R4 dut rsp ready", dut_rsp_ready_o, 1);
      repeat (r) @(negedge clk);
      dut_rsp_data_i = model(dut_seen) ^ RES_W'(bad);
      dut_rsp_valid_i = 1'b1;
      @(negedge clk);
      dut_rsp_valid_i = 1'b0;
      dut_rsp_data_i = '0;
   endtask

   // Second start while busy, with different data: must be ignored
   task automatic busy_start(input logic [DATA_W-1:0] x);
      @(negedge clk);
      chk(done_o == 1'b0, "R5 done low while busy", done_o, 0);
      in_data_i = ~x;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic watch_cmp(input int exp_n, input bit bad);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cmp_valid_o && n < 60);
      chk(n == exp_n, "R6 compare cycle", n, exp_n);
      chk(cmp_pass_o == !bad, "R7 pass bit", cmp_pass_o, !bad);
   endtask

   task automatic run_case(input int qr, input int rr, input int qd, input int rd,
                           input logic [DATA_W-1:0] x, input bit bad,
                           inout int exp_req, inout bit exp_err);
      int lat = (qr + rr > qd + rd) ? (qr + rr) : (qd + rd);
      chk(done_o == 1'b1, "R5 done when idle", done_o, 1);
      start_i = 1'b1;
      in_data_i = x;
      fork
         busy_start(x);
         ref_side(qr, rr, x);
         dut_side(qd, rd, x, bad);
         watch_cmp(4 + lat, bad);
      join
      exp_req += 2;
      if (bad) exp_err = 1'b1;
      chk(ref_seen == x && dut_seen == x, "R1 operand to both units", dut_seen, x);
      @(negedge clk);
      chk(done_o == 1'b1, "R5 done after compare", done_o, 1);
      chk(cmp_valid_o == 1'b0, "R7 strobe one cycle", cmp_valid_o, 0);
      chk(err_sticky_o == exp_err, "R8 sticky flag", err_sticky_o, exp_err);
      chk(req_count_o == CNT_W'(exp_req), "R9 request count", req_count_o, exp_req);
      chk(rsp_count_o == CNT_W'(exp_req), "R9 response count", rsp_count_o, exp_req);
   endtask

   initial begin
      int exp_req = 0;
      bit exp_err = 1'b0;
      int idx = 0;
      repeat (3) @(negedge clk);
      chk(done_o == 1'b1, "R10 reset done", done_o, 1);
      chk(req_count_o == '0 && rsp_count_o == '0, "R10 reset counters", req_count_o, 0);
      chk(err_sticky_o == 1'b0, "R10 reset sticky", err_sticky_o, 0);
      chk(!ref_req_valid_o && !dut_req_valid_o && !ref_rsp_ready_o && !dut_rsp_ready_o,
          "R10 reset handshakes", ref_req_valid_o, 0);
      chk(!cmp_valid_o && !cmp_pass_o, "R10 reset compare", cmp_valid_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int qr = 0; qr < 3; qr++)
         for (int rr = 0; rr < 3; rr++)
            for (int qd = 0; qd < 3; qd++)
               for (int rd = 0; rd < 3; rd++) begin
                  run_case(qr, rr, qd, rd, DATA_W'(idx * 37 + 5), (idx % 9) == 4,
                           exp_req, exp_err);
                  idx++;
               end
      // R1: idle with start low causes no traffic
      repeat (3) begin
         @(negedge clk);
         chk(done_o && !ref_req_valid_o && !dut_req_valid_o, "R1 no start no request",
             ref_req_valid_o, 0);
      end
      summary();
      $finish;
   end

endmodule